// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character per request into a serial frame on a single output line that rests at logic 1. A frame is a low start bit, then 5 to 8 data bits sent least significant first, then an optional parity bit, then a high stop period. The stop period may last half a bit, one bit, one and a half bits or two bits. The data, the character length, the parity mode, the stop length and the rate are all sampled in the cycle the request is accepted, and they stay fixed until the frame ends.

Timing comes from an internal divider. Its input gives the number of system clocks in one half bit, and every full bit lasts exactly two half bits. This half-bit base is what allows the fractional stop lengths. To get a baud rate, set the divider to the system clock frequency divided by twice the rate. For example, a 100 MHz clock gives 9600 baud with a value of 5208.

While a frame is in flight the block reports busy, and it ignores any further request. When the stop period finishes, a one-clock done pulse appears and busy falls in the same cycle. A request made in that cycle starts the next frame with no idle gap.

Top module: `sertx_core`

## Requirements
- R1: After reset, `line_o` is 1, `busy_o` is 0 and `done_o` is 0. The line stays at 1 whenever no frame is in flight.
- R2: A request is accepted on a rising clock edge where `start_i` is 1 and `busy_o` is 0. From the next cycle, the line carries a start bit of 0 lasting one bit time.
- R3: After the start bit come N data bits, least significant first, one bit time each. N is 5, 6, 7 or 8 for `len_sel_i` values 0, 1, 2 and 3. Data bits above N are not sent.
- R4: `par_sel_i` selects the parity bit placed after the data: 0 gives no parity bit, 1 gives odd parity, 2 gives even parity, 3 gives a bit that is always 1, and 4 gives a bit that is always 0. Codes 5 to 7 behave like 0. Odd and even parity are taken over the N sent data bits only.
- R5: The stop period holds the line at 1. For `stop_sel_i` values 0, 1, 2 and 3 it lasts 1, 2, 3 and 4 half bits.
- R6: One half bit lasts `half_div_i` clocks, and a value of 0 acts as 1. A full bit lasts exactly two half bits, so a whole frame lasts (2·(1+N+P)+S)·D clocks, where P is 1 when a parity bit is sent, S is the stop length in half bits and D is the effective divider.
- R7: Data, length, parity, stop and divider inputs are sampled at acceptance. Changing them while `busy_o` is 1 has no effect on the frame in flight.
- R8: While `busy_o` is 1, `start_i` is ignored: the frame in flight is neither restarted nor extended.
- R9: `done_o` is 1 for exactly one clock: the first cycle after the stop period ends. `busy_o` is 0 in that cycle, and a request made in that cycle is accepted.
- R10: `busy_o` is 1 from the cycle after acceptance until the stop period ends, and it falls only together with a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request strobe |
| data_i | input | DATA_W | Character to send |
| len_sel_i | input | LEN_W | Character length code (0 = 5 bits … 3 = 8 bits) |
| par_sel_i | input | 3 | Parity mode code |
| stop_sel_i | input | 2 | Stop length code, in half bits minus one |
| half_div_i | input | DIV_W | System clocks per half bit |
| line_o | output | 1 | Serial output line, idles high |
| busy_o | output | 1 | Frame in flight |
| done_o | output | 1 | One-clock pulse at the end of the stop period |

## Verification
Directed frames come first. They walk every length code with a character whose high bits differ from its low bits, so a wrong length shows up as extra or missing bits. They try each parity code on characters of odd and of even weight, which separates odd from even and mark from space, and they drive the unused codes 5 to 7. They try each stop length at a divider large enough that one half bit stands apart from a whole bit, and a divider of 0 to check that it behaves as 1.

Further frames keep `start_i` high and scramble every configuration input while the frame runs, which shows whether anything is sampled after acceptance. Frames are also sent back to back, so each request falls in the done cycle of the frame before it. A fixed-seed random mix of all settings follows. Each output is compared cycle by cycle with a model of the frame built from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // frame sequencing phases
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_START  = 3'd1,
      PH_DATA   = 3'd2,
      PH_PARITY = 3'd3,
      PH_STOP   = 3'd4
   } phase_t;

   // parity mode codes; other values mean no parity bit
   localparam logic [2:0] PAR_NONE  = 3'd0;
   localparam logic [2:0] PAR_ODD   = 3'd1;
   localparam logic [2:0] PAR_EVEN  = 3'd2;
   localparam logic [2:0] PAR_MARK  = 3'd3;
   localparam logic [2:0] PAR_SPACE = 3'd4;

   // character length for a length code, clamped to the data width
   function automatic int unsigned code_to_len(input int unsigned code,
                                               input int unsigned min_len,
                                               input int unsigned max_len);
      int unsigned n;
      n = min_len + code;
      if (n > max_len) n = max_len;
      return n;
   endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] lim_i,
   output logic             tick_o
);

   if (DIV_W < 2) begin : g_bad_div_w
      $error("sertx_baud: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last_w;

   // a limit of zero behaves like one clock per half bit
   assign last_w = (lim_i == '0) ? '0 : lim_i - DIV_W'(1);
   assign tick_o = run_i && (cnt_q >= last_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || tick_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + DIV_W'(1);
   end

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= last_w));

   // R6
   tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int LEN_W   = 2
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [2:0]        mode_i,
   output logic              en_o,
   output logic              bit_o
);

   localparam int NCODE = 1 << LEN_W;

   if (MIN_LEN < 1 || DATA_W < MIN_LEN) begin : g_bad_len
      $error("sertx_parity: need 1 <= MIN_LEN <= DATA_W");
   end

   logic [DATA_W-1:0] mask_tab [NCODE];
   logic [DATA_W-1:0] mask_w;
   logic              xor_w;

   // one mask per length code, built at elaboration
   for (genvar g = 0; g < NCODE; g++) begin : g_mask
      localparam int unsigned NB = code_to_len(g, MIN_LEN, DATA_W);
      assign mask_tab[g] = {DATA_W{1'b1}} >> (DATA_W - NB);
   end

   assign mask_w = mask_tab[len_i];
   assign xor_w  = ^(data_i & mask_w);

   always_comb begin
      en_o  = 1'b1;
      bit_o = 1'b0;
      case (mode_i)
         PAR_ODD:   bit_o = ~xor_w;
         PAR_EVEN:  bit_o = xor_w;
         PAR_MARK:  bit_o = 1'b1;
         PAR_SPACE: bit_o = 1'b0;
         default:   en_o  = 1'b0;
      endcase
   end

endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int LEN_W   = 2,
   parameter int DIV_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [1:0]        stop_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              par_en_i,
   input  logic              par_bit_i,
   input  logic              tick_i,
   output logic [DIV_W-1:0]  lim_o,
   output logic              line_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   phase_t            ph_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  last_q;
   logic [2:0]        half_q;
   logic [2:0]        stop_q;
   logic              pen_q;
   logic              pbit_q;
   logic [DIV_W-1:0]  div_q;
   logic              done_q;

   logic              accept_w;
   logic [2:0]        need_w;
   logic              seg_end_w;

   assign accept_w  = start_i && (ph_q == PH_IDLE);
   assign need_w    = (ph_q == PH_STOP) ? stop_q : 3'd2;
   assign seg_end_w = tick_i && (half_q == need_w - 3'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         sh_q   <= '0;
         idx_q  <= '0;
         last_q <= '0;
         half_q <= '0;
         stop_q <= 3'd1;
         pen_q  <= 1'b0;
         pbit_q <= 1'b0;
         div_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_w) begin
            ph_q   <= PH_START;
            sh_q   <= data_i;
            idx_q  <= '0;
            half_q <= '0;
            last_q <= CNT_W'(code_to_len(32'(len_i), MIN_LEN, DATA_W) - 1);
            stop_q <= {1'b0, stop_i} + 3'd1;
            pen_q  <= par_en_i;
            pbit_q <= par_bit_i;
            div_q  <= div_i;
         end else if (tick_i) begin
            if (seg_end_w) begin
               half_q <= '0;
               case (ph_q)
                  PH_START: ph_q <= PH_DATA;
                  PH_DATA: begin
                     sh_q <= sh_q >> 1;
                     if (idx_q == last_q)
                        ph_q <= pen_q ? PH_PARITY : PH_STOP;
                     else
                        idx_q <= idx_q + CNT_W'(1);
                  end
                  PH_PARITY: ph_q <= PH_STOP;
                  PH_STOP: begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b1;
                  end
                  default: ph_q <= PH_IDLE;
               endcase
            end else begin
               half_q <= half_q + 3'd1;
            end
         end
      end
   end

   always_comb begin
      case (ph_q)
         PH_START:  line_o = 1'b0;
         PH_DATA:   line_o = sh_q[0];
         PH_PARITY: line_o = pbit_q;
         default:   line_o = 1'b1;
      endcase
   end

   assign busy_o = (ph_q != PH_IDLE);
   assign done_o = done_q;
   assign lim_o  = div_q;

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> line_o);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !line_o);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R10
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R6
   line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !$past(tick_i)) |-> $stable(line_o));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int DIV_W   = 16,
   localparam int LEN_W  = (DATA_W - MIN_LEN + 1 > 1) ? $clog2(DATA_W - MIN_LEN + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LEN_W-1:0]  len_sel_i,
   input  logic [2:0]        par_sel_i,
   input  logic [1:0]        stop_sel_i,
   input  logic [DIV_W-1:0]  half_div_i,
   output logic              line_o,
   output logic              busy_o,
   output logic              done_o
);

   if (DATA_W > 64) begin : g_bad_data_w
      $error("sertx_core: DATA_W above 64 is not supported");
   end

   logic             tick_w;
   logic [DIV_W-1:0] lim_w;
   logic             pen_w;
   logic             pbit_w;

   sertx_parity #(
      .DATA_W  (DATA_W),
      .MIN_LEN (MIN_LEN),
      .LEN_W   (LEN_W)
   ) u_parity (
      .data_i (data_i),
      .len_i  (len_sel_i),
      .mode_i (par_sel_i),
      .en_o   (pen_w),
      .bit_o  (pbit_w)
   );

   sertx_baud #(
      .DIV_W (DIV_W)
   ) u_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy_o),
      .lim_i  (lim_w),
      .tick_o (tick_w)
   );

   sertx_frame_fsm #(
      .DATA_W  (DATA_W),
      .MIN_LEN (MIN_LEN),
      .LEN_W   (LEN_W),
      .DIV_W   (DIV_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .data_i    (data_i),
      .len_i     (len_sel_i),
      .stop_i    (stop_sel_i),
      .div_i     (half_div_i),
      .par_en_i  (pen_w),
      .par_bit_i (pbit_w),
      .tick_i    (tick_w),
      .lim_o     (lim_w),
      .line_o    (line_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

endmodule

// File: tb/sertx_core_test.sv
module sertx_core_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [7:0]  data_i;
   logic [1:0]  len_sel_i;
   logic [2:0]  par_sel_i;
   logic [1:0]  stop_sel_i;
   logic [15:0] half_div_i;
   logic        line_o;
   logic        busy_o;
   logic        done_o;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   sertx_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .data_i     (data_i),
      .len_sel_i  (len_sel_i),
      .par_sel_i  (par_sel_i),
      .stop_sel_i (stop_sel_i),
      .half_div_i (half_div_i),
      .line_o     (line_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_par(input logic [7:0] d, input int lc, input int pm);
      int n    = lc + 5;
      int ones = $countones(d & 8'((1 << n) - 1));
      case (pm)
         1:       return (ones % 2) == 0;
         2:       return (ones % 2) == 1;
         3:       return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit exp_line(input logic [7:0] d, input int lc, input int pm,
                                   input int deff, input int idx);
      int n    = lc + 5;
      int slot = (idx / deff) / 2;
      bit pu   = (pm >= 1) && (pm <= 4);
      if (slot == 0) return 1'b0;
      if (slot <= n) return d[slot-1];
      if (pu && slot == n + 1) return exp_par(d, lc, pm);
      return 1'b1;
   endfunction

   // called at a falling edge; returns at the falling edge of the done cycle
   task automatic run_frame(input logic [7:0] d, input int lc, input int pm, input int sc,
                            input int dv, input bit perturb, input string tag);
      int  deff = (dv == 0) ? 1 : dv;
      int  pu   = (pm >= 1 && pm <= 4) ? 1 : 0;
      int  tlen = (2 * (1 + lc + 5 + pu) + sc + 1) * deff;
      bit  miss = 1'b0;
      int  at   = 0;
      int  act  = 0;
      int  exv  = 0;
      chk(busy_o == 1'b0, "R2 ready before request", int'(busy_o), 0);
      start_i    = 1'b1;
      data_i     = d;
      len_sel_i  = 2'(lc);
      par_sel_i  = 3'(pm);
      stop_sel_i = 2'(sc);
      half_div_i = 16'(dv);
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < tlen; i++) begin
         bit e = exp_line(d, lc, pm, deff, i);
         if (!miss && (line_o !== e || busy_o !== 1'b1 || done_o !== 1'b0)) begin
            miss = 1'b1;
            at   = i;
            act  = {29'd0, line_o, busy_o, done_o};
            exv  = {29'd0, e, 1'b1, 1'b0};
         end
         if (perturb && i < tlen - 1) begin
            start_i    = 1'b1;
            data_i     = 8'($urandom);
            len_sel_i  = 2'($urandom);
            par_sel_i  = 3'($urandom);
            stop_sel_i = 2'($urandom);
            half_div_i = 16'($urandom % 5);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      chk(!miss, $sformatf("%s R10 frame {line,busy,done} at cycle %0d", tag, at), act, exv);
      chk(done_o == 1'b1, {tag, " R9 done pulse"}, int'(done_o), 1);
      chk(busy_o == 1'b0, {tag, " R10 busy low at end"}, int'(busy_o), 0);
      chk(line_o == 1'b1, {tag, " R5 line high after stop"}, int'(line_o), 1);
   endtask

   task automatic idle_check(input int cycles);
      bit ok = 1'b1;
      start_i = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (line_o !== 1'b1 || busy_o !== 1'b0 || done_o !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R1 R9 idle line high, no busy, single done", int'(ok), 1);
   endtask

   initial begin
      void'($urandom(32'd20517));
      rst_n      = 1'b0;
      start_i    = 1'b0;
      data_i     = '0;
      len_sel_i  = '0;
      par_sel_i  = '0;
      stop_sel_i = '0;
      half_div_i = 16'd1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(line_o == 1'b1, "R1 reset line", int'(line_o), 1);
      chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
      rst_n = 1'b1;
      idle_check(12);

      // R2 R3 R6 plain 8 bit, no parity, one stop bit
      run_frame(8'hA5, 3, 0, 1, 3, 1'b0, "R2 R3 R6 8-bit");
      idle_check(4);
      // R3 each length; high bits differ from low bits
      for (int lc = 0; lc < 4; lc++)
         run_frame(8'h1A | 8'hE0, lc, 2, 1, 2, 1'b0, "R3 length");
      // R4 parity codes on odd and even weight characters
      for (int pm = 0; pm < 8; pm++) begin
         run_frame(8'h37, 3, pm, 1, 2, 1'b0, "R4 parity odd weight");
         run_frame(8'h36, 2, pm, 1, 2, 1'b0, "R4 parity even weight");
      end
      // R5 stop lengths, half bit = 4 clocks
      for (int sc = 0; sc < 4; sc++)
         run_frame(8'h5C, 1, 1, sc, 4, 1'b0, "R5 stop length");
      // R6 divider of zero and a larger divider
      run_frame(8'hC3, 3, 3, 3, 0, 1'b0, "R6 divider zero");
      run_frame(8'h69, 0, 4, 0, 9, 1'b0, "R6 divider nine");
      // R7 R8 inputs scrambled and start held while busy
      run_frame(8'hF0, 3, 2, 2, 3, 1'b1, "R7 R8 held start");
      run_frame(8'h0F, 0, 1, 0, 1, 1'b1, "R7 R8 held start");
      run_frame(8'h81, 2, 3, 3, 2, 1'b1, "R7 R8 held start");
      idle_check(6);

      // random mix; back-to-back calls also place requests in the done cycle (R9)
      for (int k = 0; k < 40; k++) begin
         run_frame(8'($urandom), int'($urandom % 4), int'($urandom % 8),
                   int'($urandom % 4), int'($urandom % 6), 1'($urandom % 3 == 0),
                   "R3 R4 R5 R9 random");
         if ($urandom % 4 == 0) idle_check(int'($urandom % 5) + 1);
      end
      idle_check(5);

      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule